// File: doc/BRIEF.md
# Packed Saturating Add/Subtract Unit

This unit performs packed signed arithmetic on two 32-bit operands, `rn` and `rm`, in one registered stage. A 3-bit operation code chooses between two 16-bit lanes and four 8-bit lanes. Each lane is clamped to the signed range of its width instead of wrapping. Two of the halfword operations swap the halfwords of `rm` before combining them with `rn`. In these modes one lane adds and the other subtracts.

Operands and code are sampled when `in_valid` is high. The result, a per-lane clamp indication and an illegal-code flag appear on the next cycle, together with `out_valid`. Overflow is detected from the sign bits of the operands and of the wrapped result. No wider intermediate sum is formed.

Top module: `sat_simd_alu`

## Requirements
- R1: Code 0 gives result[15:0]=rn[15:0]+rm[15:0] and result[31:16]=rn[31:16]+rm[31:16]. Code 3 gives the same two lanes with subtraction (rn minus rm). Each lane is clamped to the signed 16-bit range.
- R2: Code 1 gives low = rn[15:0]−rm[31:16] and high = rn[31:16]+rm[15:0]. Code 2 gives low = rn[15:0]+rm[31:16] and high = rn[31:16]−rm[15:0]. Both lanes are clamped to the signed 16-bit range.
- R3: Code 4 adds and code 7 subtracts the four bytes rn[8k+7:8k] and rm[8k+7:8k], for k=0..3. Each byte result goes back to bits 8k+7:8k, is clamped to the signed 8-bit range, and no carry passes between bytes.
- R4: An add that overflows gives 0x7FFF or 0x7F when the left operand is non-negative. It gives 0x8000 or 0x80 when the left operand is negative.
- R5: A subtract overflows only when the operand signs differ. It then gives the same extreme value as R4, chosen by the sign of the left operand (rn).
- R6: Codes 5 and 6 are reserved. They give result 0, sat_flags 0 and illegal=1 in the cycle where out_valid is 1. illegal is 0 whenever out_valid is 0.
- R7: out_valid equals in_valid of the previous cycle. A synchronous reset clears out_valid, illegal, result and sat_flags.
- R8: result and sat_flags keep their value in any cycle that follows an edge where in_valid was 0.
- R9: In the byte codes, sat_flags[k] is 1 exactly when byte k was clamped. In the halfword codes, sat_flags[1:0] both report the low lane and sat_flags[3:2] both report the high lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and code are valid |
| op | input | 3 | Operation code |
| rn | input | 32 | Left operand |
| rm | input | 32 | Right operand |
| out_valid | output | 1 | Registered result valid |
| result | output | 32 | Packed clamped result |
| sat_flags | output | 4 | Per-byte-position clamp indication |
| illegal | output | 1 | Reserved code was issued |

## Verification
The assertions assume that `in_valid` is low while reset is held. They also assume that `op`, `rn` and `rm` are at defined levels whenever `in_valid` is high. The bench changes inputs only at the falling edge. It keeps `in_valid` low through reset and the idle gaps, and it drives every code, reserved ones included, only with valid operands. The operand sweep combines lane values at the signed limits and around zero across all eight codes, then adds a pseudo-random stream. Every byte and halfword therefore meets both overflow directions and the non-overflow boundary.

// File: rtl/sat_simd_alu.sv
module sat_simd_alu #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [2:0]    op,
  input  logic [DW-1:0] rn,
  input  logic [DW-1:0] rm,
  output logic          out_valid,
  output logic [DW-1:0] result,
  output logic [3:0]    sat_flags,
  output logic          illegal
);
  localparam int HW = DW / 2;
  localparam int BW = DW / 4;
  localparam int NB = DW / BW;

  function automatic logic [HW:0] sat_h(input logic [HW-1:0] a, input logic [HW-1:0] b, input logic sub);
    logic [HW-1:0] r;
    logic ov;
    r  = sub ? a - b : a + b;
    ov = (sub ? (a[HW-1] ^ b[HW-1]) : ~(a[HW-1] ^ b[HW-1])) & (r[HW-1] ^ a[HW-1]);
    return {ov, ov ? {a[HW-1], {(HW-1){~a[HW-1]}}} : r};
  endfunction

  function automatic logic [BW:0] sat_b(input logic [BW-1:0] a, input logic [BW-1:0] b, input logic sub);
    logic [BW-1:0] r;
    logic ov;
    r  = sub ? a - b : a + b;
    ov = (sub ? (a[BW-1] ^ b[BW-1]) : ~(a[BW-1] ^ b[BW-1])) & (r[BW-1] ^ a[BW-1]);
    return {ov, ov ? {a[BW-1], {(BW-1){~a[BW-1]}}} : r};
  endfunction

  logic              xchg;
  logic [HW:0]       h_lo, h_hi;
  logic [NB-1:0][BW:0] b_r;
  logic [DW-1:0]     nxt_res;
  logic [3:0]        nxt_sat;
  logic              nxt_ill;

  assign xchg = (op == 3'd1) || (op == 3'd2);
  assign h_lo = sat_h(rn[HW-1:0], xchg ? rm[DW-1:HW] : rm[HW-1:0], (op == 3'd1) || (op == 3'd3));
  assign h_hi = sat_h(rn[DW-1:HW], xchg ? rm[HW-1:0] : rm[DW-1:HW], (op == 3'd2) || (op == 3'd3));

  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign b_r[g] = sat_b(rn[g*BW +: BW], rm[g*BW +: BW], op == 3'd7);
  end

  assign nxt_ill = (op == 3'd5) || (op == 3'd6);

  always_comb begin
    nxt_res = '0;
    nxt_sat = '0;
    case (op)
      3'd0, 3'd1, 3'd2, 3'd3: begin
        nxt_res = {h_hi[HW-1:0], h_lo[HW-1:0]};
        nxt_sat = {h_hi[HW], h_hi[HW], h_lo[HW], h_lo[HW]};
      end
      3'd4, 3'd7: begin
        for (int k = 0; k < NB; k++) begin
          nxt_res[k*BW +: BW] = b_r[k][BW-1:0];
          nxt_sat[k]          = b_r[k][BW];
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      result    <= '0;
      sat_flags <= '0;
    end else begin
      out_valid <= in_valid;
      illegal   <= in_valid && nxt_ill;
      if (in_valid) begin
        result    <= nxt_res;
        sat_flags <= nxt_sat;
      end
    end
  end

  assert_valid_follow_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> out_valid == $past(in_valid));
  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> !out_valid && !illegal && result == '0 && sat_flags == '0);
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result) && $stable(sat_flags));
  assert_illegal_zero_R6: assert property (@(posedge clk) disable iff (rst)
    illegal |-> out_valid && result == '0 && sat_flags == '0);
  assert_illegal_code_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid && (op == 3'd5 || op == 3'd6) |=> illegal);
endmodule

// File: tb/sat_simd_alu_test.sv
module sat_simd_alu_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] rn = '0, rm = '0;
  logic        out_valid, illegal;
  logic [31:0] result;
  logic [3:0]  sat_flags;

  int total = 0, bad = 0;
  bit done = 0;

  sat_simd_alu uut (.clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .rn(rn), .rm(rm),
                    .out_valid(out_valid), .result(result), .sat_flags(sat_flags), .illegal(illegal));

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%08h exp=%08h", req, act, exp);
    end
  endtask

  function automatic int sx(input int v, input int w);
    return (v >= (1 << (w-1))) ? v - (1 << w) : v;
  endfunction

  function automatic int lane(input int a, input int b, input bit sub, input int w, output bit f);
    int s, lo, hi;
    lo = -(1 << (w-1));
    hi = (1 << (w-1)) - 1;
    s  = sub ? sx(a, w) - sx(b, w) : sx(a, w) + sx(b, w);
    f  = 1'b0;
    if (s > hi) begin s = hi; f = 1'b1; end
    else if (s < lo) begin s = lo; f = 1'b1; end
    return s & ((1 << w) - 1);
  endfunction

  task automatic model(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] er, output logic [3:0] es, output logic ei);
    int l, h;
    bit fl, fh, fb;
    logic [15:0] bl, bh;
    er = '0; es = '0; ei = 1'b0;
    if (c <= 3'd3) begin
      bl = (c == 3'd1 || c == 3'd2) ? b[31:16] : b[15:0];
      bh = (c == 3'd1 || c == 3'd2) ? b[15:0] : b[31:16];
      l = lane(int'(a[15:0]), int'(bl), c == 3'd1 || c == 3'd3, 16, fl);
      h = lane(int'(a[31:16]), int'(bh), c == 3'd2 || c == 3'd3, 16, fh);
      er = {h[15:0], l[15:0]};
      es = {fh, fh, fl, fl};
    end else if (c == 3'd4 || c == 3'd7) begin
      for (int k = 0; k < 4; k++) begin
        l = lane(int'(a[8*k +: 8]), int'(b[8*k +: 8]), c == 3'd7, 8, fb);
        er[8*k +: 8] = l[7:0];
        es[k] = fb;
      end
    end else ei = 1'b1;
  endtask

  function automatic string tag(input logic [2:0] c);
    case (c)
      3'd0, 3'd3: return "R1";
      3'd1, 3'd2: return "R2";
      3'd4, 3'd7: return "R3";
      default:    return "R6";
    endcase
  endfunction

  task automatic run(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] er;
    logic [3:0]  es;
    logic        ei;
    model(c, a, b, er, es, ei);
    @(negedge clk);
    in_valid = 1'b1; op = c; rn = a; rm = b;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 out_valid", {31'd0, out_valid}, 32'd1);
    check({tag(c), " result"}, result, er);
    check("R9 sat_flags", {28'd0, sat_flags}, {28'd0, es});
    check("R6 illegal", {31'd0, illegal}, {31'd0, ei});
  endtask

  logic [7:0] corner [9] = '{8'h00, 8'h01, 8'h7E, 8'h7F, 8'h80, 8'h81, 8'hFF, 8'h40, 8'hC0};

  initial begin
    logic [31:0] seed, a, b, hold;
    repeat (3) @(negedge clk);
    check("R7 reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R7 reset result", result, 32'd0);
    check("R7 reset sat", {28'd0, sat_flags}, 32'd0);
    check("R6 reset illegal", {31'd0, illegal}, 32'd0);
    rst = 1'b0;

    run(3'd0, 32'h7FFF_0001, 32'h0001_0001);
    check("R4 add positive clamp", result, 32'h7FFF_0002);
    run(3'd0, 32'h8000_0000, 32'hFFFF_0000);
    check("R4 add negative clamp", result, 32'h8000_0000);
    run(3'd3, 32'h8000_7FFF, 32'h0001_FFFF);
    check("R5 sub clamps", result, 32'h8000_7FFF);
    run(3'd3, 32'hFFFF_0000, 32'hFFFF_0001);
    check("R5 same sign no clamp", result, 32'h0000_FFFF);
    run(3'd4, 32'h7F80_00FF, 32'h0180_0001);
    check("R3 byte no carry", result, 32'h7F80_0000);
    check("R9 byte flags", {28'd0, sat_flags}, 32'hC);
    run(3'd7, 32'h807F_0000, 32'h01FF_0000);
    check("R5 byte sub clamp", result, 32'h807F_0000);

    hold = result;
    @(negedge clk); in_valid = 1'b0; op = 3'd0; rn = 32'h1234_5678; rm = 32'h1111_1111;
    @(negedge clk);
    check("R8 hold result", result, hold);
    check("R7 idle out_valid", {31'd0, out_valid}, 32'd0);

    run(3'd5, 32'h1, 32'h1);
    @(negedge clk);
    check("R6 illegal pulse ends", {31'd0, illegal}, 32'd0);

    for (int c = 0; c < 8; c++)
      for (int i = 0; i < 9; i++)
        for (int j = 0; j < 9; j++) begin
          a = {corner[i], corner[j], corner[(i+1)%9], corner[(j+3)%9]};
          b = {corner[j], corner[(i+4)%9], corner[(i+2)%9], corner[(j+5)%9]};
          run(3'(c), a, b);
        end

    seed = 32'h1ACE_B00C;
    for (int n = 0; n < 1200; n++) begin
      seed = seed * 32'd1664525 + 32'd1013904223; a = seed;
      seed = seed * 32'd1664525 + 32'd1013904223; b = seed;
      run(3'(n % 8), a, b);
    end

    @(negedge clk); in_valid = 1'b1; op = 3'd6; rn = 32'hFFFF_FFFF; rm = 32'h1;
    @(negedge clk); in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R7 mid reset valid", {31'd0, out_valid}, 32'd0);
    check("R7 mid reset illegal", {31'd0, illegal}, 32'd0);
    rst = 1'b0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R7 watchdog act=%08h exp=%08h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule